// File: doc/BRIEF.md
# Column Drive Gating for a Multiplexed Dot-Matrix Display

This block sits between the font lookup and the column drivers of an eight-character dot-matrix display. For each row slot it receives the raw dot pattern of the 20 columns being driven. These are four character groups of five columns each, and each group is tagged with the index of the character it shows. The block turns that pattern into the final column enables.

It applies the brightness level from the control word as an on-time fraction of a 15-step sub-slot counter. It also applies a per-character flash gate and a whole-display blink gate, both driven by a slow blink phase from the timing block, and a lamp-test override that lights every dot at a fixed mid duty. The drive level while a column is on is never changed; only the fraction of sub-slots in which it is on.

The result is registered once, so the enables follow the inputs by one clock.

Top module: `dig_column_gate`

## Requirements
- R1: Control bits [2:0] select the on-count out of 15 sub-slot steps: 000→15, 001→12, 010→8, 011→6, 100→4, 101→3, 110→2. A dot is enabled only while `pwm_cnt_i` is below that count; counter values 15 and above enable nothing.
- R2: Level code 111 forces all 20 enables low, and this overrides lamp test, blink and flash.
- R3: With lamp test off, an enable is never high unless the matching bit of `dots_i` is high.
- R4: When control bit 4 is set and `blink_ph_i` is low, all enables are low. When the phase is high, the output is the same as with bit 4 clear.
- R5: When control bit 3 is set and `blink_ph_i` is low, the five columns of group g are low if `flash_bits_i[idx]` is 1. Here idx is `grp_idx_i[3g+2:3g]` and group g drives columns [5g+4:5g]. Other groups are unaffected. With bit 3 clear, the flash bits have no effect.
- R6: When control bit 6 is set and the level is not 111, all 20 enables are high while `pwm_cnt_i` < 8 and low otherwise. This holds regardless of the dot pattern, blink and flash.
- R7: Control bits 5 and 7 have no effect on the enables.
- R8: `col_en_o` is low during reset and, after reset, shows in each cycle the gating of the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dots_i | input | 20 | Raw dot pattern of the current row slot |
| grp_idx_i | input | 12 | Character index (3 bits) for each of the four column groups |
| flash_bits_i | input | 8 | Per-character flash flags |
| ctrl_i | input | 8 | Control word |
| blink_ph_i | input | 1 | Slow blink phase, high = visible |
| pwm_cnt_i | input | 4 | Sub-slot step counter, 0..14 |
| col_en_o | output | 20 | Gated column enables |

## Verification
Each of the eight levels is swept across every counter value with a dense and a sparse dot pattern. This separates an off-by-one in any on-count from a wrong table entry.

Flash runs with distinct index-to-group mappings and both phases. This shows whether the right group is gated and whether the index is decoded rather than the group position.

Lamp test is tried with blank dots, with blink active and with the blank level. This confirms its place in the priority order. Patterns with bits 5 and 7 toggled must match those with the bits cleared.

// File: rtl/dig_gate_pkg.sv
package dig_gate_pkg;

  // Control word fields; positions are fixed by the host write format.
  typedef struct packed {
    logic       clr;    // bit 7, handled elsewhere
    logic       lamp;   // bit 6
    logic       spare;  // bit 5
    logic       blink;  // bit 4
    logic       flash;  // bit 3
    logic [2:0] level;  // bits 2..0
  } ctrl_t;

  localparam logic [2:0] LVL_BLANK = 3'b111;
  localparam int unsigned LAMP_PCT = 53;

  // Nominal duty in percent for each brightness code.
  function automatic int unsigned pct_of(logic [2:0] lvl);
    case (lvl)
      3'd0:    return 100;
      3'd1:    return 80;
      3'd2:    return 53;
      3'd3:    return 40;
      3'd4:    return 27;
      3'd5:    return 20;
      3'd6:    return 13;
      default: return 0;
    endcase
  endfunction

  // Rounded number of counter steps for a duty.
  function automatic int unsigned on_steps(int unsigned pct, int unsigned steps);
    return (pct * steps + 50) / 100;
  endfunction

endpackage

// File: rtl/dig_duty_gen.sv
module dig_duty_gen
  import dig_gate_pkg::*;
#(
  parameter int unsigned PWM_STEPS = 15,
  localparam int unsigned PWM_W = $clog2(PWM_STEPS + 1)
) (
  input  logic [2:0]       level_i,
  input  logic [PWM_W-1:0] pwm_cnt_i,
  output logic             blank_o,
  output logic             duty_on_o,
  output logic             lamp_on_o
);

  localparam int unsigned LAMP_STEPS = on_steps(LAMP_PCT, PWM_STEPS);

  logic [31:0] cnt_ext;
  logic [31:0] on_cnt;

  always_comb begin
    cnt_ext   = 32'(pwm_cnt_i);
    on_cnt    = on_steps(pct_of(level_i), PWM_STEPS);
    blank_o   = (level_i == LVL_BLANK);
    duty_on_o = (cnt_ext < on_cnt);
    lamp_on_o = (cnt_ext < LAMP_STEPS);
  end

endmodule

// File: rtl/dig_group_mask.sv
module dig_group_mask #(
  parameter int unsigned NUM_CHARS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_CHARS)
) (
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [NUM_CHARS-1:0] flash_bits_i,
  input  logic                 flash_en_i,
  input  logic                 phase_i,
  output logic                 keep_o
);

  logic char_flashing;

  always_comb begin
    char_flashing = flash_bits_i[idx_i];
    keep_o        = !(flash_en_i && char_flashing && !phase_i);
  end

endmodule

// File: rtl/dig_column_gate.sv
module dig_column_gate
  import dig_gate_pkg::*;
#(
  parameter int unsigned NUM_GROUPS     = 4,
  parameter int unsigned COLS_PER_GROUP = 5,
  parameter int unsigned NUM_CHARS      = 8,
  parameter int unsigned PWM_STEPS      = 15,
  localparam int unsigned NCOL  = NUM_GROUPS * COLS_PER_GROUP,
  localparam int unsigned IDX_W = $clog2(NUM_CHARS),
  localparam int unsigned PWM_W = $clog2(PWM_STEPS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCOL-1:0]             dots_i,
  input  logic [NUM_GROUPS*IDX_W-1:0] grp_idx_i,
  input  logic [NUM_CHARS-1:0]        flash_bits_i,
  input  logic [7:0]                  ctrl_i,
  input  logic                        blink_ph_i,
  input  logic [PWM_W-1:0]            pwm_cnt_i,
  output logic [NCOL-1:0]             col_en_o
);

  ctrl_t cw;
  assign cw = ctrl_t'(ctrl_i);

  logic blank, duty_on, lamp_on;

  dig_duty_gen #(.PWM_STEPS(PWM_STEPS)) u_duty (
    .level_i   (cw.level),
    .pwm_cnt_i (pwm_cnt_i),
    .blank_o   (blank),
    .duty_on_o (duty_on),
    .lamp_on_o (lamp_on)
  );

  logic [NUM_GROUPS-1:0] grp_keep;
  logic [NCOL-1:0]       flash_mask;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    dig_group_mask #(.NUM_CHARS(NUM_CHARS)) u_mask (
      .idx_i        (grp_idx_i[g*IDX_W +: IDX_W]),
      .flash_bits_i (flash_bits_i),
      .flash_en_i   (cw.flash),
      .phase_i      (blink_ph_i),
      .keep_o       (grp_keep[g])
    );
    assign flash_mask[g*COLS_PER_GROUP +: COLS_PER_GROUP] = {COLS_PER_GROUP{grp_keep[g]}};
  end

  // Next-state: fixed priority blank > lamp > blink > flash > duty.
  logic [NCOL-1:0] col_d, col_q;

  always_comb begin
    if (blank) begin
      col_d = '0;
    end else if (cw.lamp) begin
      col_d = {NCOL{lamp_on}};
    end else if (cw.blink && !blink_ph_i) begin
      col_d = '0;
    end else begin
      col_d = dots_i & flash_mask & {NCOL{duty_on}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_q <= '0;
    else        col_q <= col_d;
  end

  assign col_en_o = col_q;

  // Blank level wins over everything (R2)
  p_blank_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[2:0] == 3'b111) |=> (col_en_o == '0));

  // Lamp test lights all columns in the low counter steps (R6)
  p_lamp_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[2:0] != 3'b111 && ctrl_i[6] && pwm_cnt_i < 8) |=> (&col_en_o));

  // Blink low phase darkens the display (R4)
  p_blink_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i[6] && ctrl_i[4] && !blink_ph_i) |=> (col_en_o == '0));

  // Output never exceeds the pattern outside lamp test (R3)
  p_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i[6]) |=> ((col_en_o & ~$past(dots_i)) == '0));

  // Last counter step is dark for every level (R1)
  p_last_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i[6] && pwm_cnt_i >= PWM_W'(PWM_STEPS)) |=> (col_en_o == '0));

endmodule

// File: tb/dig_column_gate_tb.sv
module dig_column_gate_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] dots;
  logic [11:0] gidx;
  logic [7:0]  fbits;
  logic [7:0]  ctrl;
  logic        ph;
  logic [3:0]  pwm;
  logic [19:0] col;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dig_column_gate u_dut (
    .clk(clk), .rst_n(rst_n), .dots_i(dots), .grp_idx_i(gidx),
    .flash_bits_i(fbits), .ctrl_i(ctrl), .blink_ph_i(ph),
    .pwm_cnt_i(pwm), .col_en_o(col)
  );

  function automatic logic [19:0] model(logic [19:0] d, logic [11:0] ix,
      logic [7:0] fb, logic [7:0] c, logic p, logic [3:0] n);
    int tab[8] = '{15, 12, 8, 6, 4, 3, 2, 0};
    logic [19:0] r;
    if (c[2:0] == 3'd7) return 20'h0;
    if (c[6]) return (n < 8) ? 20'hFFFFF : 20'h0;
    if (c[4] && !p) return 20'h0;
    r = (int'(n) < tab[c[2:0]]) ? d : 20'h0;
    for (int g = 0; g < 4; g++)
      if (c[3] && !p && fb[ix[g*3 +: 3]]) r[g*5 +: 5] = 5'b0;
    return r;
  endfunction

  task automatic check(string req, logic [19:0] exp);
    checks++;
    if (col !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (ctrl=%h pwm=%0d ph=%b)", req, col, exp, ctrl, pwm, ph);
    end
  endtask

  // Drive at negedge, let one rising edge pass, compare at next negedge.
  task automatic step(string req, logic [19:0] d, logic [11:0] ix,
      logic [7:0] fb, logic [7:0] c, logic p, logic [3:0] n);
    dots = d; gidx = ix; fbits = fb; ctrl = c; ph = p; pwm = n;
    @(posedge clk);
    @(negedge clk);
    check(req, model(d, ix, fb, c, p, n));
  endtask

  initial begin
    rst_n = 1'b0;
    dots = 20'hFFFFF; gidx = 12'h0; fbits = 8'h0; ctrl = 8'h0; ph = 1'b1; pwm = 4'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (col !== 20'h0) begin
      errors++;
      $display("FAIL R8 reset: got %h expected %h", col, 20'h0);
    end
    rst_n = 1'b1;

    // R1/R2/R3: every level across every counter step, two patterns
    for (int lv = 0; lv < 8; lv++)
      for (int n = 0; n < 16; n++) begin
        step("R1", 20'hFFFFF, 12'o3210, 8'h0, 8'(lv), 1'b1, 4'(n));
        step("R3", 20'h5A3C1, 12'o3210, 8'h0, 8'(lv), 1'b1, 4'(n));
      end

    // R5: flash with distinct index maps and both phases
    for (int k = 0; k < 24; k++) begin
      logic [11:0] ix = 12'($urandom);
      logic [7:0]  fb = 8'($urandom);
      step("R5", 20'hFFFFF, ix, fb, 8'h08, k[0], 4'd2);
      step("R5", 20'hFFFFF, ix, fb, 8'h00, 1'b0, 4'd2);
    end
    step("R5", 20'hFFFFF, 12'o0123, 8'h01, 8'h08, 1'b0, 4'd0);
    step("R5", 20'hFFFFF, 12'o7777, 8'h80, 8'h09, 1'b0, 4'd5);

    // R4: blink, with and without flash
    step("R4", 20'hFFFFF, 12'o3210, 8'hFF, 8'h10, 1'b0, 4'd0);
    step("R4", 20'h12345, 12'o3210, 8'h00, 8'h10, 1'b1, 4'd0);
    step("R4", 20'hFFFFF, 12'o3210, 8'h0F, 8'h18, 1'b1, 4'd1);

    // R6: lamp test over all steps, ignoring dots, blink and flash
    for (int n = 0; n < 16; n++) begin
      step("R6", 20'h0, 12'o3210, 8'hFF, 8'h5E, 1'b0, 4'(n));
      step("R6", 20'h0, 12'o3210, 8'h00, 8'h43, 1'b1, 4'(n));
    end
    // R2: blank beats lamp test
    step("R2", 20'hFFFFF, 12'o3210, 8'h00, 8'h47, 1'b1, 4'd0);

    // R7: bits 5 and 7 ignored
    for (int k = 0; k < 16; k++) begin
      logic [19:0] d = 20'($urandom);
      step("R7", d, 12'o3210, 8'h0, 8'hA0 | 8'(k % 7), 1'b1, 4'(k));
      step("R7", d, 12'o3210, 8'h0, 8'h20, 1'b1, 4'd14);
    end

    // R8: one-cycle latency on a change
    step("R8", 20'hFFFFF, 12'o3210, 8'h0, 8'h00, 1'b1, 4'd0);
    dots = 20'h0;
    @(posedge clk); #1;
    checks++;
    if (col !== 20'h0) begin
      errors++;
      $display("FAIL R8 latency: got %h expected %h", col, 20'h0);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule